// File: doc/BRIEF.md
# Send Descriptor Ring Packer

The packer turns one outbound packet request into a run of 128-bit send descriptors and writes them into a circular ring that a DMA engine reads. A request carries a header buffer (address and dword length), zero or more payload segments (address and byte length each) and three per-packet options: large buffer, head write-back and completion interrupt. The packer writes the header descriptor first and then one descriptor per segment, one descriptor per clock, at consecutive ring slots starting from its tail.

The block keeps the ring tail and a generation counter that advances every time the tail wraps. When the whole packet is in the ring, it publishes the new tail to the engine with a one-cycle strobe. It also reports the slot after the header descriptor and the final tail as the packet's start and next indices. A request is held off while a packet is in progress, or when the ring lacks room for all of its descriptors, judged against the engine's consumed index.

Top module: `desc_ring_packer`

## Requirements
- R1: After reset the tail and generation are 0, no descriptor write and no tail strobe are issued, and a header-only request is accepted into the empty ring.
- R2: Word 1 holds address bits 47:32 in its bits 15:0 with all higher bits zero; word 0 bits 63:32 hold address bits 31:0 with bits 33:32 written as zero whatever the request supplies.
- R3: The header descriptor is written first, with the header dword count, buffer offset 0, and the first flag (word 0 bit 12) set; no other descriptor has that flag.
- R4: A payload descriptor has dword count ceil(bytes/4) in word 0 bits 26:16 and a buffer offset in word 0 bits 10:0 equal to the header dwords plus the dwords of all earlier segments of the packet.
- R5: Word 0 bit 14 (large buffer) is set on every descriptor of a packet that asks for it; bit 11 (last), bit 13 (head write-back) and bit 15 (interrupt) appear only on the packet's final descriptor, the latter two only when requested.
- R6: Word 0 bits 31:30 carry the generation counter at the time of writing; the generation increments when a write goes to the last ring slot and the tail wraps to 0.
- R7: Descriptors are written one per clock at consecutive slots, starting at the tail in the cycle after acceptance and wrapping from the last slot to 0.
- R8: The tail strobe is high for exactly one cycle, the cycle after the final descriptor write, with the next index equal to the new tail and the start index equal to the slot after the header descriptor.
- R9: Ready is low while a packet is being written or its strobe is pending, and whenever (segments + 1) exceeds the free slots, counted as depth − 1 − ((tail − engine head) mod depth).

Default ring depth is 256 slots; a depth parameter of 0 selects 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_hdr_addr | input | AW | Header buffer address |
| req_hdr_dw | input | 11 | Header length in dwords |
| req_nseg | input | SC_W | Number of payload segments |
| req_seg_addr | input | MAX_SEGS*AW | Segment addresses, segment 0 in the low bits |
| req_seg_len | input | MAX_SEGS*LW | Segment byte lengths, segment 0 in the low bits |
| req_large | input | 1 | Large buffer option |
| req_headwb | input | 1 | Head write-back option |
| req_intr | input | 1 | Completion interrupt option |
| eng_head | input | IDX_W | Engine's consumed ring index |
| dw_en | output | 1 | Descriptor write strobe |
| dw_idx | output | IDX_W | Ring slot being written |
| dw_w0 | output | 64 | Descriptor word 0 |
| dw_w1 | output | 64 | Descriptor word 1 |
| tail_upd | output | 1 | Tail publish strobe |
| pkt_start | output | IDX_W | Slot after the header descriptor |
| pkt_next | output | IDX_W | New tail |

## Verification
Two functions meet in one cycle when a packet's final descriptor falls in the last ring slot: the last flag, the wrap to slot 0, the generation step and, one cycle later, a published tail of 0 all follow from that single write. A second meeting is the room check against an engine head that moves in the very cycle a request is judged. An eight-slot ring with random packet sizes makes wraps land on every descriptor position, and a bench-side engine that stalls at random keeps the ring near full. A behavioural model rebuilds every descriptor, the ready decision and the strobe each clock and compares them field by field.

// File: rtl/desc_ring_packer.sv
module desc_ring_packer #(
  parameter int RING_DEPTH = 256,
  parameter int MAX_SEGS   = 4,
  parameter int AW         = 48,
  parameter int LW         = 13,
  localparam int DEPTH = (RING_DEPTH == 0) ? 256 : RING_DEPTH,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SC_W  = $clog2(MAX_SEGS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_hdr_addr,
  input  logic [10:0]            req_hdr_dw,
  input  logic [SC_W-1:0]        req_nseg,
  input  logic [MAX_SEGS*AW-1:0] req_seg_addr,
  input  logic [MAX_SEGS*LW-1:0] req_seg_len,
  input  logic                   req_large,
  input  logic                   req_headwb,
  input  logic                   req_intr,
  input  logic [IDX_W-1:0]       eng_head,
  output logic                   dw_en,
  output logic [IDX_W-1:0]       dw_idx,
  output logic [63:0]            dw_w0,
  output logic [63:0]            dw_w1,
  output logic                   tail_upd,
  output logic [IDX_W-1:0]       pkt_start,
  output logic [IDX_W-1:0]       pkt_next
);
  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

  logic                   busy, upd;
  logic [IDX_W-1:0]       tail, start_q, tail_nx;
  logic [1:0]             gen;
  logic [SC_W-1:0]        k, nseg, sel;
  logic [AW-1:0]          haddr, cur_addr;
  logic [10:0]            hdw, acc, cur_cnt, cur_off;
  logic [MAX_SEGS*AW-1:0] saddr;
  logic [MAX_SEGS*LW-1:0] slen;
  logic [LW:0]            rnd;
  logic                   fl_large, fl_wb, fl_int, last, first, wrap;
  logic [IDX_W:0]         used, free;

  assign used = (tail >= eng_head) ? ({1'b0, tail} - {1'b0, eng_head})
                                   : ({1'b0, tail} + DEPTH_V - {1'b0, eng_head});
  assign free = DEPTH_V - 1'b1 - used;
  assign req_ready = !busy && !upd && (32'(req_nseg) <= 32'(MAX_SEGS)) &&
                     (32'(req_nseg) + 32'd1 <= 32'(free));

  assign sel   = k - 1'b1;
  assign first = (k == '0);
  assign last  = (k == nseg);
  assign rnd   = {1'b0, slen[sel*LW +: LW]} + (LW+1)'(3);

  always_comb begin
    if (first) begin
      cur_addr = haddr;
      cur_cnt  = hdw;
      cur_off  = '0;
    end else begin
      cur_addr = saddr[sel*AW +: AW];
      cur_cnt  = 11'(rnd >> 2);
      cur_off  = acc;
    end
  end

  assign wrap    = (32'(tail) == DEPTH - 1);
  assign tail_nx = wrap ? '0 : tail + 1'b1;

  assign dw_en  = busy;
  assign dw_idx = tail;
  assign dw_w0  = {cur_addr[31:2], 2'b00, gen, 3'b000, cur_cnt,
                   fl_int & last, fl_large, fl_wb & last, first, last, cur_off};
  assign dw_w1  = 64'(cur_addr >> 32);
  assign tail_upd  = upd;
  assign pkt_start = start_q;
  assign pkt_next  = tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; upd <= 1'b0; tail <= '0; start_q <= '0; gen <= '0;
      k <= '0; nseg <= '0; haddr <= '0; hdw <= '0; acc <= '0;
      saddr <= '0; slen <= '0; fl_large <= 1'b0; fl_wb <= 1'b0; fl_int <= 1'b0;
    end else begin
      upd <= busy && last;
      if (req_valid && req_ready) begin
        busy  <= 1'b1;
        k     <= '0;
        nseg  <= req_nseg;
        haddr <= req_hdr_addr;
        hdw   <= req_hdr_dw;
        acc   <= req_hdr_dw;
        saddr <= req_seg_addr;
        slen  <= req_seg_len;
        fl_large <= req_large;
        fl_wb    <= req_headwb;
        fl_int   <= req_intr;
      end else if (busy) begin
        tail <= tail_nx;
        if (wrap) gen <= gen + 2'd1;
        if (first) start_q <= tail_nx;
        else       acc <= acc + cur_cnt;
        k <= k + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/desc_ring_packer_chk.sv
module desc_ring_packer_chk #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             dw_en,
  input logic [IDX_W-1:0] dw_idx,
  input logic [63:0]      dw_w0,
  input logic             tail_upd
);
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en |-> dw_w0[33:32] == 2'b00);

  p_seq_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && $past(dw_en) |->
      dw_idx == ((32'($past(dw_idx)) == DEPTH - 1) ? '0 : $past(dw_idx) + 1'b1));

  p_gen_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && $past(dw_en) && 32'($past(dw_idx)) == DEPTH - 1 |->
      dw_w0[31:30] == $past(dw_w0[31:30]) + 2'd1);

  p_first_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && !$past(dw_en) |-> dw_w0[12]);

  p_first_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && $past(dw_en) |-> !dw_w0[12]);

  p_large_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && $past(dw_en) |-> dw_w0[14] == $past(dw_w0[14]));

  p_final_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en && !dw_w0[11] |-> !dw_w0[13] && !dw_w0[15]);

  p_upd_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_upd |-> $past(dw_en) && $past(dw_w0[11]) && !dw_en);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dw_en && !tail_upd);
endmodule

bind desc_ring_packer desc_ring_packer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dw_en(dw_en),
  .dw_idx(dw_idx), .dw_w0(dw_w0), .tail_upd(tail_upd)
);

// File: tb/desc_ring_packer_tb.sv
module desc_ring_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NS = 3;
  localparam int AW = 48;
  localparam int LW = 13;
  localparam int IW = 3;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0;
  logic r_valid = 0, r_large = 0, r_wb = 0, r_int = 0;
  logic [AW-1:0] r_haddr = '0;
  logic [10:0] r_hdw = '0;
  logic [SW-1:0] r_nseg = '0;
  logic [AW-1:0] r_sa [NS];
  logic [LW-1:0] r_sl [NS];
  logic [NS*AW-1:0] seg_addr;
  logic [NS*LW-1:0] seg_len;
  logic [IW-1:0] hw_head = '0;
  logic req_ready, dw_en, tail_upd;
  logic [IW-1:0] dw_idx, pkt_start, pkt_next;
  logic [63:0] dw_w0, dw_w1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NS; i++) begin
      seg_addr[i*AW +: AW] = r_sa[i];
      seg_len[i*LW +: LW]  = r_sl[i];
    end

  desc_ring_packer #(.RING_DEPTH(DEPTH), .MAX_SEGS(NS), .AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_ready(req_ready),
    .req_hdr_addr(r_haddr), .req_hdr_dw(r_hdw), .req_nseg(r_nseg),
    .req_seg_addr(seg_addr), .req_seg_len(seg_len), .req_large(r_large),
    .req_headwb(r_wb), .req_intr(r_int), .eng_head(hw_head),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_w0(dw_w0), .dw_w1(dw_w1),
    .tail_upd(tail_upd), .pkt_start(pkt_start), .pkt_next(pkt_next));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [63:0] q_w0 [$];
  logic [63:0] q_w1 [$];
  int q_idx [$];
  bit q_hdr [$];
  int m_tail = 0, m_gen = 0, m_start = 0, m_next = 0, m_pub = 0;
  bit m_upd = 0, took = 0, eng_on = 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic build();
    int t = m_tail;
    int off = r_hdw;
    for (int d = 0; d <= int'(r_nseg); d++) begin
      logic [AW-1:0] a;
      int cnt, of;
      bit lst;
      logic [63:0] w0;
      lst = (d == int'(r_nseg));
      if (d == 0) begin a = r_haddr; cnt = r_hdw; of = 0; end
      else begin
        a = r_sa[d-1]; cnt = (int'(r_sl[d-1]) + 3) / 4; of = off; off += cnt;
      end
      w0 = '0;
      w0[63:32] = {a[31:2], 2'b00};
      w0[31:30] = 2'(m_gen);
      w0[26:16] = 11'(cnt);
      w0[10:0]  = 11'(of);
      w0[15] = r_int & lst;
      w0[14] = r_large;
      w0[13] = r_wb & lst;
      w0[12] = (d == 0);
      w0[11] = lst;
      q_w0.push_back(w0);
      q_w1.push_back(64'(a[AW-1:32]));
      q_idx.push_back(t);
      q_hdr.push_back(d == 0);
      t++;
      if (t == DEPTH) begin t = 0; m_gen = (m_gen + 1) % 4; end
      if (d == 0) m_start = t;
    end
    m_tail = t;
    m_next = t;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int used, freec;
      bit exp_rdy, nupd;
      string ct;
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
      used = (m_tail - int'(hw_head) + DEPTH) % DEPTH;
      freec = DEPTH - 1 - used;
      exp_rdy = (q_w0.size() == 0) && !m_upd && (int'(r_nseg) + 1 <= freec);
      chk("R9 ready", 64'(req_ready), 64'(exp_rdy));
      if (q_w0.size() != 0) begin
        ct = q_hdr[0] ? "R3 count/offset" : "R4 count/offset";
        chk("R7 write strobe", 64'(dw_en), 64'd1);
        chk("R7 slot", 64'(dw_idx), 64'(q_idx[0]));
        chk("R2 word1", dw_w1, q_w1[0]);
        chk("R2 address", 64'(dw_w0[63:32]), 64'(q_w0[0][63:32]));
        chk("R6 generation", 64'(dw_w0[31:30]), 64'(q_w0[0][31:30]));
        chk(ct, 64'({dw_w0[29:16], dw_w0[10:0]}), 64'({q_w0[0][29:16], q_w0[0][10:0]}));
        chk("R3 first flag", 64'(dw_w0[12]), 64'(q_w0[0][12]));
        chk("R5 flags", 64'({dw_w0[15:13], dw_w0[11]}), 64'({q_w0[0][15:13], q_w0[0][11]}));
      end else
        chk("R7 no write", 64'(dw_en), 64'd0);
      chk("R8 strobe", 64'(tail_upd), 64'(m_upd));
      if (m_upd) begin
        chk("R8 next index", 64'(pkt_next), 64'(m_next));
        chk("R8 start index", 64'(pkt_start), 64'(m_start));
        m_pub = m_next;
      end
      nupd = 0;
      if (q_w0.size() != 0) begin
        void'(q_w0.pop_front()); void'(q_w1.pop_front());
        void'(q_idx.pop_front()); void'(q_hdr.pop_front());
        if (q_w0.size() == 0) nupd = 1;
      end
      m_upd = nupd;
      took = r_valid && exp_rdy;
      if (took) build();
    end
  end

  always @(posedge clk) begin
    #1;
    if (eng_on && int'(hw_head) != m_pub) hw_head <= (int'(hw_head) == DEPTH - 1) ? '0 : hw_head + 1'b1;
  end

  task automatic send(logic [AW-1:0] ha, int hdw, int ns, int l0, int l1, int l2,
                      bit lg, bit wb, bit it, int hold);
    r_haddr = ha; r_hdw = 11'(hdw); r_nseg = SW'(ns);
    r_sl[0] = LW'(l0); r_sl[1] = LW'(l1); r_sl[2] = LW'(l2);
    r_sa[0] = ha + 48'h1000; r_sa[1] = {ha[23:0], ha[47:24]} & ~48'h3; r_sa[2] = ha ^ 48'hA5A5_0000_F00C;
    r_large = lg; r_wb = wb; r_int = it; r_valid = 1;
    repeat (hold) begin @(posedge clk); #1; end
    eng_on = 1;
    do begin @(posedge clk); #1; end while (!took);
    r_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin r_sa[i] = '0; r_sl[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset write", 64'(dw_en), 64'd0);
    chk("R1 reset strobe", 64'(tail_upd), 64'd0);
    chk("R1 reset tail", 64'(pkt_next), 64'd0);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    rst_n = 1;
    send(48'hBEEF_1234_567B, 5, 0, 0, 0, 0, 1, 1, 1, 0);
    send(48'h0000_8000_0040, 7, 3, 5, 8188, 1, 0, 1, 0, 0);
    send(48'h0012_0000_0100, 3, 2, 8, 4, 0, 1, 0, 1, 0);
    repeat (6) @(posedge clk);
    #1;
    eng_on = 0;
    send(48'h1, 1, 1, 4, 0, 0, 0, 0, 0, 0);
    eng_on = 0;
    send(48'h2, 1, 1, 4, 0, 0, 0, 0, 0, 0);
    eng_on = 0;
    send(48'h3, 1, 1, 4, 0, 0, 0, 0, 0, 0);
    eng_on = 0;
    send(48'h4, 2, 2, 12, 12, 0, 1, 1, 1, 12);
    for (int n = 0; n < 80; n++) begin
      eng_on = ($urandom % 3) != 0;
      send({$urandom, $urandom} & 48'hFFFF_FFFF_FFFC, $urandom % 40, $urandom % 4,
           1 + $urandom % 300, 1 + $urandom % 3000, 1 + $urandom % 64,
           $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
    end
    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule